// File: doc/BRIEF.md
# JTAG Instruction-Selected Debug Probe Multiplexer

This block lets a designer watch internal test nets through the JTAG data output, so no spare device pins are spent on debug. An 8-bit user instruction code picks which net is observed. The chosen net drives a single user TDO line, and the TAP logic forwards that line to the device TDO pin. The TAP state machine, instruction shifting and pads sit outside this block.

The block has three output modes. Direct mode is purely combinational. Registered mode captures the chosen net on one TCK edge, and an edge control picks the rising or the falling edge. Round-robin mode serialises a group of `GROUP_N` consecutive nets onto the output, one net per active edge, so each net is sampled at TCK/`GROUP_N`. The only clock is TCK, so the output data rate always follows TCK.

Top module: `dbg_probe_mux`

## Requirements
- R1: An instruction code from 16 to 127 selects net index (code − 16). Any other code, or any resulting net index at or above `NUM_NETS`, makes the output 0 in every mode.
- R2: With mode `2'b00` (direct), the output follows the selected net combinationally, with no TCK edge needed.
- R3: With mode `2'b01` and edge select 0, the output equals the selected net as sampled at the most recent rising TCK edge.
- R4: With mode `2'b01` and edge select 1, the output equals the selected net as sampled at the most recent falling TCK edge.
- R5: With mode `2'b10` or `2'b11` (round-robin), the k-th active edge (k = 0, 1, …) after entering the mode captures net index (code − 16 + (k mod `GROUP_N`)), and the output shows that net. The rotation counter is held at 0 while the block is in any other mode.
- R6: In round-robin mode, an active edge that sees an instruction code different from the code seen at the previous edge captures slot 0 of the new group, and the rotation continues from there.
- R7: In round-robin mode, a slot whose net index would be at or above `NUM_NETS` outputs 0.
- R8: While the active-low reset is asserted, and after its release until the first active TCK edge, the registered and round-robin output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck_i | input | 1 | JTAG test clock |
| rst_n_i | input | 1 | Asynchronous reset, active low |
| ir_code_i | input | 8 | User instruction code that selects the net |
| nets_i | input | NUM_NETS | Internal test nets |
| mode_i | input | 2 | 00 direct, 01 registered, 1x round-robin |
| edge_sel_i | input | 1 | 0 rising TCK edge, 1 falling TCK edge |
| utdo_o | output | 1 | User TDO line |

## Verification
Direct and registered modes are swept over all 256 instruction codes with two net patterns whose bits differ irregularly. Any mapping offset, off-by-one range limit or stuck bit therefore shows up as a miscompare. In one edge-discrimination pattern the nets change between the falling and the rising edge, so a swapped or shared capture edge gives the wrong value. Round-robin runs span more than two rotations on groups at the start, in the middle and at the top of the code range, which exposes wrap errors and out-of-range slots. A mid-rotation code change shows whether the counter restarts.

// File: rtl/dbg_probe_pkg.sv
package dbg_probe_pkg;

  localparam int unsigned CODE_LO = 16;
  localparam int unsigned CODE_HI = 127;

  typedef enum logic [1:0] {
    MODE_DIRECT = 2'b00,
    MODE_REG    = 2'b01,
    MODE_RR_A   = 2'b10,
    MODE_RR_B   = 2'b11
  } probe_mode_e;

  function automatic logic code_valid(input logic [7:0] code);
    return (code >= 8'(CODE_LO)) && (code <= 8'(CODE_HI));
  endfunction

  function automatic logic [8:0] code_to_index(input logic [7:0] code);
    return {1'b0, code} - 9'(CODE_LO);
  endfunction

endpackage

// File: rtl/dbg_probe_decode.sv
module dbg_probe_decode
  import dbg_probe_pkg::*;
#(
  parameter int unsigned NUM_NETS = 112
) (
  input  logic [7:0]          code_i,
  input  logic [NUM_NETS-1:0] nets_i,
  input  logic [8:0]          offset_i,
  output logic                bit_o
);

  localparam int unsigned NIW = (NUM_NETS > 1) ? $clog2(NUM_NETS) : 1;

  logic [8:0] idx;
  logic       in_range;

  always_comb begin
    idx      = code_to_index(code_i) + offset_i;
    in_range = code_valid(code_i) && (idx < 9'(NUM_NETS));
    bit_o    = in_range ? nets_i[idx[NIW-1:0]] : 1'b0;
  end

endmodule

// File: rtl/dbg_probe_lane.sv
module dbg_probe_lane
  import dbg_probe_pkg::*;
#(
  parameter int unsigned NUM_NETS = 112,
  parameter int unsigned GROUP_N  = 4,
  parameter bit          FALLING  = 1'b0,
  localparam int unsigned CW      = (GROUP_N > 1) ? $clog2(GROUP_N) : 1
) (
  input  logic                clk_i,
  input  logic                rst_n_i,
  input  logic [7:0]          code_i,
  input  logic [NUM_NETS-1:0] nets_i,
  input  logic                rr_i,
  output logic                q_o,
  output logic [CW-1:0]       cnt_o
);

  logic [7:0]    last_code;
  logic [CW-1:0] cnt;
  logic [CW-1:0] slot;
  logic [CW-1:0] cnt_nxt;
  logic          code_chg;
  logic          pick;

  always_comb begin
    code_chg = (code_i != last_code);
    slot     = (rr_i && !code_chg) ? cnt : '0;
    if (!rr_i || (slot == CW'(GROUP_N - 1)))
      cnt_nxt = '0;
    else
      cnt_nxt = slot + 1'b1;
  end

  dbg_probe_decode #(.NUM_NETS(NUM_NETS)) u_dec (
    .code_i  (code_i),
    .nets_i  (nets_i),
    .offset_i(9'(slot)),
    .bit_o   (pick)
  );

  generate
    if (FALLING) begin : g_fall
      always_ff @(negedge clk_i or negedge rst_n_i) begin
        if (!rst_n_i) begin
          q_o       <= 1'b0;
          cnt       <= '0;
          last_code <= '0;
        end else begin
          q_o       <= pick;
          cnt       <= cnt_nxt;
          last_code <= code_i;
        end
      end
    end else begin : g_rise
      always_ff @(posedge clk_i or negedge rst_n_i) begin
        if (!rst_n_i) begin
          q_o       <= 1'b0;
          cnt       <= '0;
          last_code <= '0;
        end else begin
          q_o       <= pick;
          cnt       <= cnt_nxt;
          last_code <= code_i;
        end
      end
    end
  endgenerate

  assign cnt_o = cnt;

endmodule

// File: rtl/dbg_probe_mux.sv
module dbg_probe_mux
  import dbg_probe_pkg::*;
#(
  parameter int unsigned NUM_NETS = 112,
  parameter int unsigned GROUP_N  = 4,
  localparam int unsigned CW      = (GROUP_N > 1) ? $clog2(GROUP_N) : 1
) (
  input  logic                tck_i,
  input  logic                rst_n_i,
  input  logic [7:0]          ir_code_i,
  input  logic [NUM_NETS-1:0] nets_i,
  input  logic [1:0]          mode_i,
  input  logic                edge_sel_i,
  output logic                utdo_o
);

  logic          direct_bit;
  logic          rise_q;
  logic          fall_q;
  logic [CW-1:0] rise_cnt;
  logic [CW-1:0] fall_cnt;
  logic          rr_mode;

  assign rr_mode = mode_i[1];

  dbg_probe_decode #(.NUM_NETS(NUM_NETS)) u_direct (
    .code_i  (ir_code_i),
    .nets_i  (nets_i),
    .offset_i(9'd0),
    .bit_o   (direct_bit)
  );

  dbg_probe_lane #(.NUM_NETS(NUM_NETS), .GROUP_N(GROUP_N), .FALLING(1'b0)) u_rise (
    .clk_i  (tck_i),
    .rst_n_i(rst_n_i),
    .code_i (ir_code_i),
    .nets_i (nets_i),
    .rr_i   (rr_mode),
    .q_o    (rise_q),
    .cnt_o  (rise_cnt)
  );

  dbg_probe_lane #(.NUM_NETS(NUM_NETS), .GROUP_N(GROUP_N), .FALLING(1'b1)) u_fall (
    .clk_i  (tck_i),
    .rst_n_i(rst_n_i),
    .code_i (ir_code_i),
    .nets_i (nets_i),
    .rr_i   (rr_mode),
    .q_o    (fall_q),
    .cnt_o  (fall_cnt)
  );

  always_comb begin
    if (mode_i == MODE_DIRECT)
      utdo_o = direct_bit;
    else
      utdo_o = edge_sel_i ? fall_q : rise_q;
  end

endmodule

// File: rtl/dbg_probe_mux_chk.sv
module dbg_probe_mux_chk
  import dbg_probe_pkg::*;
#(
  parameter int unsigned GROUP_N = 4,
  localparam int unsigned CW     = (GROUP_N > 1) ? $clog2(GROUP_N) : 1
) (
  input logic          tck_i,
  input logic          rst_n_i,
  input logic [7:0]    ir_code_i,
  input logic [1:0]    mode_i,
  input logic          utdo_o,
  input logic          direct_bit,
  input logic          rise_q,
  input logic          fall_q,
  input logic [CW-1:0] rise_cnt,
  input logic [CW-1:0] fall_cnt
);

  // R1: illegal code in direct mode gives 0 at the output
  a_r1_invalid_zero: assert property (@(posedge tck_i) disable iff (!rst_n_i)
    (mode_i == 2'b00 && !code_valid(ir_code_i)) |-> (utdo_o == 1'b0));

  // R3: rising lane holds the net seen at the previous rising edge
  a_r3_rise_capture: assert property (@(posedge tck_i) disable iff (!rst_n_i)
    (mode_i == 2'b01) |=> (rise_q == $past(direct_bit)));

  // R4: falling lane holds the net seen at the previous falling edge
  a_r4_fall_capture: assert property (@(negedge tck_i) disable iff (!rst_n_i)
    (mode_i == 2'b01) |=> (fall_q == $past(direct_bit)));

  // R5: rotation counters never leave 0..GROUP_N-1
  a_r5_cnt_range: assert property (@(posedge tck_i) disable iff (!rst_n_i)
    (32'(rise_cnt) < GROUP_N) && (32'(fall_cnt) < GROUP_N));

  // R5: counter is idle outside round-robin mode
  a_r5_cnt_idle: assert property (@(posedge tck_i) disable iff (!rst_n_i)
    (!mode_i[1]) |=> (rise_cnt == '0));

  // R6: a code change restarts rotation at slot 0
  a_r6_restart: assert property (@(posedge tck_i) disable iff (!rst_n_i)
    (mode_i[1] && (ir_code_i != $past(ir_code_i))) |=> (rise_cnt == CW'((GROUP_N > 1) ? 1 : 0)));

endmodule

bind dbg_probe_mux dbg_probe_mux_chk #(.GROUP_N(GROUP_N)) u_chk (
  .tck_i     (tck_i),
  .rst_n_i   (rst_n_i),
  .ir_code_i (ir_code_i),
  .mode_i    (mode_i),
  .utdo_o    (utdo_o),
  .direct_bit(direct_bit),
  .rise_q    (rise_q),
  .fall_q    (fall_q),
  .rise_cnt  (rise_cnt),
  .fall_cnt  (fall_cnt)
);

// File: tb/dbg_probe_mux_tb.sv
`timescale 1ns/100ps
module dbg_probe_mux_tb;

  localparam int NN = 112;
  localparam int GN = 4;

  logic          tck = 1'b0;
  logic          rst_n;
  logic [7:0]    code;
  logic [NN-1:0] nets;
  logic [1:0]    mode;
  logic          edge_sel;
  logic          utdo;

  int n_checks = 0;
  int n_fail   = 0;

  always #2 tck = ~tck;

  dbg_probe_mux #(.NUM_NETS(NN), .GROUP_N(GN)) u_dut (
    .tck_i     (tck),
    .rst_n_i   (rst_n),
    .ir_code_i (code),
    .nets_i    (nets),
    .mode_i    (mode),
    .edge_sel_i(edge_sel),
    .utdo_o    (utdo)
  );

  function automatic logic [NN-1:0] gen_pat(input int p);
    logic [NN-1:0] v;
    for (int i = 0; i < NN; i++)
      v[i] = (p == 0) ? ((i % 3) == 0) : (((i * 7 + 3) % 5) < 2);
    return v;
  endfunction

  function automatic logic net_at(input logic [NN-1:0] v, input int idx);
    return (idx >= 0 && idx < NN) ? v[idx] : 1'b0;
  endfunction

  function automatic logic exp_sel(input logic [NN-1:0] v, input int c, input int off);
    if (c < 16 || c > 127) return 1'b0;
    return net_at(v, c - 16 + off);
  endfunction

  task automatic check(input logic act, input logic exp, input string req);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s code=%0d mode=%0d edge=%0d actual=%b expected=%b",
               req, code, mode, edge_sel, act, exp);
    end
  endtask

  task automatic step();
    @(posedge tck);
    #1;
  endtask

  initial begin
    #(4 * 150000);
    n_fail++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end

  initial begin
    logic [NN-1:0] a;
    logic [NN-1:0] b;
    rst_n = 1'b0; code = 8'd20; nets = '1; mode = 2'b01; edge_sel = 1'b0;
    // R8: output 0 while reset asserted, both edges
    repeat (3) step();
    check(utdo, 1'b0, "R8 reset rise");
    edge_sel = 1'b1; #0.5;
    check(utdo, 1'b0, "R8 reset fall");
    edge_sel = 1'b0;
    step();
    rst_n = 1'b1; #0.5;
    check(utdo, 1'b0, "R8 after release");
    step();
    check(utdo, 1'b1, "R3 first edge after reset");

    // R1 R2: direct sweep
    mode = 2'b00;
    for (int p = 0; p < 2; p++) begin
      nets = gen_pat(p);
      for (int c = 0; c < 256; c++) begin
        code = 8'(c); #0.5;
        check(utdo, exp_sel(nets, c, 0), "R2 direct / R1 code map");
      end
    end

    // R1 R3 R4: registered sweeps
    for (int e = 0; e < 2; e++) begin
      step();
      mode = 2'b01; edge_sel = 1'(e);
      for (int c = 0; c < 256; c++) begin
        code = 8'(c); nets = gen_pat(c % 2);
        a = nets;
        step();
        check(utdo, exp_sel(a, c, 0), e ? "R4 falling capture" : "R3 rising capture");
      end
    end

    // R3 R4: nets change between falling and rising edge
    foreach (a[i]) a[i] = gen_pat(0)[i];
    b = ~a;
    for (int k = 0; k < 3; k++) begin
      int c;
      c = (k == 0) ? 16 : (k == 1) ? 70 : 127;
      step();
      mode = 2'b01; edge_sel = 1'b0; code = 8'(c); nets = a;
      #2; nets = b;
      @(posedge tck); #1;
      check(utdo, exp_sel(b, c, 0), "R3 rising edge only");
      edge_sel = 1'b1; #0.5;
      check(utdo, exp_sel(a, c, 0), "R4 falling edge only");
    end

    // R5 R7: round-robin over several groups, both edges
    for (int e = 0; e < 2; e++) begin
      for (int j = 0; j < 6; j++) begin
        int c;
        c = (j == 0) ? 16 : (j == 1) ? 60 : (j == 2) ? 125 : (j == 3) ? 127 : (j == 4) ? 5 : 200;
        step();
        mode = 2'b00;
        step();
        mode = (j % 2) ? 2'b11 : 2'b10; edge_sel = 1'(e);
        code = 8'(c); nets = gen_pat(j % 2); a = nets;
        for (int k = 0; k < 2 * GN + 2; k++) begin
          step();
          check(utdo, exp_sel(a, c, k % GN), (c >= 125) ? "R7 slot range" : "R5 rotation");
        end
      end
    end

    // R6: code change mid-rotation restarts at slot 0
    for (int e = 0; e < 2; e++) begin
      step();
      mode = 2'b00;
      step();
      mode = 2'b10; edge_sel = 1'(e); code = 8'd30; nets = gen_pat(1); a = nets;
      step(); check(utdo, exp_sel(a, 30, 0), "R6 pre slot0");
      step(); check(utdo, exp_sel(a, 30, 1), "R6 pre slot1");
      code = 8'd40;
      for (int k = 0; k < GN + 1; k++) begin
        step();
        check(utdo, exp_sel(a, 40, k % GN), "R6 restart after change");
      end
      code = 8'd31;
      step(); check(utdo, exp_sel(a, 31, 0), "R6 second restart");
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end

endmodule